// File: doc/BRIEF.md
# DMA Block Segmenter and Length Checker

This block sits between a scatter-gather descriptor fetcher and the card data path of a storage host controller. For each descriptor it takes the byte length and cuts it into chunks that never cross a card block boundary. Each chunk carries the byte offset inside the current block where it starts and its byte count. A block that is only partly filled when a descriptor runs out stays partly filled, and the next descriptor of the same chain continues from that offset. Every completed block gives a strobe. When block counting is on, each completed block also decrements a block counter.

A chain is opened with a one-cycle start pulse. The pulse loads the block count, empties the partial block and clears the error status. The chain ends when a descriptor flagged as the last one runs out, or when the block counter reaches zero. At that point the block checks that the end marker, the remaining descriptor length and the block count agree. If they do not, it raises a length-mismatch status, a transfer-state error code and, if enabled, an error interrupt. Moving memory and card data is left to the surrounding logic. This block only says which bytes go where and when the card must supply or take a block. The block size must be nonzero.

Top module: `blk_seg_split`

## Requirements
- R1: The block size is taken from the low 12 bits of the 16-bit `blk_size_reg` input; the upper 4 bits have no effect.
- R2: While `chunk_valid` is high, one chunk is produced per clock. `chunk_offset` equals the current fill offset. `chunk_bytes` equals the smaller of (block size minus fill offset) and the descriptor bytes still remaining.
- R3: The fill offset carries over from one descriptor to the next within a chain. When a chunk fills the block exactly, `blk_done` pulses with that chunk and the fill offset returns to zero.
- R4: With `cnt_en` high, `blk_cnt` decrements by one in the cycle after each `blk_done`. With `cnt_en` low it never changes during a chain.
- R5: With `cnt_en` high, the descriptor and the chain stop as soon as `blk_cnt` reaches zero, even if descriptor bytes remain.
- R6: A descriptor length of 0 is segmented as 65536 bytes.
- R7: At chain completion, `mismatch` is set if any of these holds: descriptor bytes remain; the end marker was seen with `cnt_en` high and a nonzero count; or the count reached zero with `cnt_en` high and no end marker.
- R8: When `mismatch` is set, `err_state` becomes 2'b11, and `err_irq` is set only if `err_irq_en` is high. With no mismatch, `err_state` is 2'b00 and `err_irq` is 0.
- R9: A `chain_start` pulse while idle loads `blk_cnt` from `blk_cnt_init`, clears the fill offset, and clears `mismatch`, `err_state` and `err_irq`.
- R10: For reads (`dir_read`=1), `card_rd_req` pulses with every chunk whose offset is 0. For writes, `card_wr_push` pulses with every chunk that completes a block.
- R11: `done` pulses for one cycle in the cycle after the chain's final chunk. `desc_ready` is high whenever no descriptor is being segmented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chain_start | input | 1 | Open a new chain (idle only) |
| blk_size_reg | input | 16 | Block size register, low 12 bits used |
| dir_read | input | 1 | 1 = card-to-memory, 0 = memory-to-card |
| cnt_en | input | 1 | Block counting enable |
| blk_cnt_init | input | 16 | Block count loaded at chain start |
| err_irq_en | input | 1 | Error interrupt enable |
| desc_valid | input | 1 | Descriptor offered |
| desc_len | input | 16 | Descriptor byte length, 0 means 65536 |
| desc_end | input | 1 | Descriptor is the last of the chain |
| desc_ready | output | 1 | Block idle, descriptor accepted |
| chunk_valid | output | 1 | Chunk outputs valid this cycle |
| chunk_offset | output | 12 | Start offset of chunk inside block |
| chunk_bytes | output | 12 | Byte count of chunk |
| blk_done | output | 1 | Chunk completes a block |
| card_rd_req | output | 1 | Fetch a fresh block from the card |
| card_wr_push | output | 1 | Push the completed block to the card |
| blk_cnt | output | 16 | Current block count |
| done | output | 1 | Chain complete pulse |
| mismatch | output | 1 | Length mismatch status |
| err_state | output | 2 | 2'b11 transfer-state error, 2'b00 none |
| err_irq | output | 1 | Error interrupt |

## Verification
A corrupted fill offset shows at once on `chunk_offset` of the next chunk. It also shows one chunk later as a wrong `chunk_bytes` or a misplaced `blk_done`, `card_rd_req` or `card_wr_push`. A wrong block counter shows on `blk_cnt` the cycle after a block completes. It also makes the chain stop at the wrong chunk, which shows as an early or late `done`. A wrong remaining-length value shows as the wrong chunk count within the descriptor and as a spurious or missing `mismatch` at the next chain end.

// File: rtl/seg_pkg.sv
// Shared types for the block segmenter.
// Assumes nothing beyond IEEE 1800-2017 packages.
package seg_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEG  = 1'b1
    } seg_state_t;

    localparam logic [1:0] ERR_NONE = 2'b00;
    localparam logic [1:0] ERR_TFR  = 2'b11;
endpackage

// File: rtl/seg_chunk_calc.sv
// Chunk arithmetic: given block size, fill offset and remaining bytes,
// produces the chunk size, whether it completes the block, and the next
// fill offset and remaining length. Purely combinational.
// Assumes bs is nonzero and fill < bs.
module seg_chunk_calc #(
    parameter int BSW = 12,
    parameter int LW  = 17
) (
    input  logic [BSW-1:0] bs,
    input  logic [BSW-1:0] fill,
    input  logic [LW-1:0]  rem,
    output logic [BSW-1:0] take,
    output logic           blk_full,
    output logic [BSW-1:0] fill_next,
    output logic [LW-1:0]  rem_next
);
    logic [BSW-1:0] room;

    // pick the smaller of block room and remaining length
    always_comb begin
        room = bs - fill;
        if (rem < LW'(room)) take = rem[BSW-1:0];
        else                 take = room;
        blk_full  = (take == room);
        fill_next = blk_full ? '0 : fill + take;
        rem_next  = rem - LW'(take);
    end
endmodule

// File: rtl/seg_blk_counter.sv
// Block counter: loads at chain start, decrements per completed block.
// Also exposes the value it will hold after this cycle.
// Assumes load and dec are never high together.
module seg_blk_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] init,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          zero_next
);
    logic [CW-1:0] cnt_next;

    // value after this cycle's decrement
    always_comb begin
        cnt_next  = dec ? cnt - CW'(1) : cnt;
        zero_next = (cnt_next == '0);
    end

    // counter register
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= init;
        else           cnt <= cnt_next;
    end
endmodule

// File: rtl/seg_len_check.sv
// End-of-chain length agreement check and sticky error status.
// Evaluated only in the cycle the chain finishes; cleared at chain start.
module seg_len_check (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       finish,
    input  logic       bytes_left,
    input  logic       end_attr,
    input  logic       cnt_en,
    input  logic       cnt_zero,
    input  logic       irq_en,
    output logic       mismatch,
    output logic [1:0] err_state,
    output logic       err_irq
);
    import seg_pkg::*;

    logic bad;

    // the three disagreement cases
    always_comb begin
        bad = bytes_left
            | (end_attr & cnt_en & ~cnt_zero)
            | (cnt_en & cnt_zero & ~end_attr);
    end

    // sticky status registers
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            mismatch  <= 1'b0;
            err_state <= ERR_NONE;
            err_irq   <= 1'b0;
        end else if (finish && bad) begin
            mismatch  <= 1'b1;
            err_state <= ERR_TFR;
            err_irq   <= err_irq | irq_en;
        end
    end
endmodule

// File: rtl/blk_seg_split.sv
// Top: accepts descriptors, emits one block-bounded chunk per cycle,
// tracks the partial block across descriptors and checks chain length.
// Assumes block size (low 12 bits) is nonzero.
module blk_seg_split #(
    parameter int BSW = 12,
    parameter int CW  = 16,
    parameter int DLW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           chain_start,
    input  logic [15:0]    blk_size_reg,
    input  logic           dir_read,
    input  logic           cnt_en,
    input  logic [CW-1:0]  blk_cnt_init,
    input  logic           err_irq_en,
    input  logic           desc_valid,
    input  logic [DLW-1:0] desc_len,
    input  logic           desc_end,
    output logic           desc_ready,
    output logic           chunk_valid,
    output logic [BSW-1:0] chunk_offset,
    output logic [BSW-1:0] chunk_bytes,
    output logic           blk_done,
    output logic           card_rd_req,
    output logic           card_wr_push,
    output logic [CW-1:0]  blk_cnt,
    output logic           done,
    output logic           mismatch,
    output logic [1:0]     err_state,
    output logic           err_irq
);
    import seg_pkg::*;

    localparam int LW = DLW + 1;

    seg_state_t     state;
    logic [BSW-1:0] fill;
    logic [LW-1:0]  rem;
    logic           end_q;
    logic [BSW-1:0] bs;
    logic [BSW-1:0] take;
    logic           full;
    logic [BSW-1:0] fill_nx;
    logic [LW-1:0]  rem_nx;
    logic           seg_on;
    logic           dec;
    logic           cnt_zero_nx;
    logic           desc_last;
    logic           chain_fin;
    logic           accept;
    logic           start_ok;

    // decode block size and handshakes
    always_comb begin
        bs          = blk_size_reg[BSW-1:0];
        seg_on      = (state == ST_SEG);
        start_ok    = chain_start && (state == ST_IDLE);
        accept      = desc_valid && (state == ST_IDLE) && !chain_start;
        desc_ready  = (state == ST_IDLE);
        dec         = seg_on && full && cnt_en;
    end

    seg_chunk_calc #(.BSW(BSW), .LW(LW)) u_calc (
        .bs        (bs),
        .fill      (fill),
        .rem       (rem),
        .take      (take),
        .blk_full  (full),
        .fill_next (fill_nx),
        .rem_next  (rem_nx)
    );

    seg_blk_counter #(.CW(CW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start_ok),
        .init      (blk_cnt_init),
        .dec       (dec),
        .cnt       (blk_cnt),
        .zero_next (cnt_zero_nx)
    );

    // descriptor and chain termination decisions
    always_comb begin
        desc_last = seg_on && ((rem_nx == '0) || (cnt_en && full && cnt_zero_nx));
        chain_fin = desc_last && (end_q || (cnt_en && cnt_zero_nx));
    end

    seg_len_check u_chk_len (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (start_ok),
        .finish     (chain_fin),
        .bytes_left (rem_nx != '0),
        .end_attr   (end_q),
        .cnt_en     (cnt_en),
        .cnt_zero   (cnt_zero_nx),
        .irq_en     (err_irq_en),
        .mismatch   (mismatch),
        .err_state  (err_state),
        .err_irq    (err_irq)
    );

    // chunk outputs, valid while segmenting
    always_comb begin
        chunk_valid  = seg_on;
        chunk_offset = fill;
        chunk_bytes  = seg_on ? take : '0;
        blk_done     = seg_on && full;
        card_rd_req  = seg_on && dir_read && (fill == '0);
        card_wr_push = seg_on && !dir_read && full;
    end

    // state, fill offset and remaining length registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            fill  <= '0;
            rem   <= '0;
            end_q <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= chain_fin;
            if (start_ok) begin
                fill <= '0;
            end else if (accept) begin
                state <= ST_SEG;
                rem   <= (desc_len == '0) ? (LW'(1) << DLW) : LW'(desc_len);
                end_q <= desc_end;
            end else if (seg_on) begin
                fill <= fill_nx;
                rem  <= rem_nx;
                if (desc_last) state <= ST_IDLE;
            end
        end
    end
endmodule

// File: rtl/blk_seg_split_chk.sv
// Property checker for blk_seg_split, observing its ports only.
module blk_seg_split_chk #(
    parameter int BSW = 12,
    parameter int CW  = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           chain_start,
    input logic [15:0]    blk_size_reg,
    input logic           dir_read,
    input logic           cnt_en,
    input logic           desc_ready,
    input logic           chunk_valid,
    input logic [BSW-1:0] chunk_offset,
    input logic [BSW-1:0] chunk_bytes,
    input logic           blk_done,
    input logic           card_rd_req,
    input logic           card_wr_push,
    input logic [CW-1:0]  blk_cnt,
    input logic           done,
    input logic           mismatch,
    input logic [1:0]     err_state
);
    // R2: chunk nonempty and inside the block
    assert_chunk_fits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_valid |-> (chunk_bytes != '0) &&
        ((BSW+1)'(chunk_offset) + (BSW+1)'(chunk_bytes) <= (BSW+1)'(blk_size_reg[BSW-1:0])));

    // R3: block strobe only when the chunk reaches the block end
    assert_blk_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> ((BSW+1)'(chunk_offset) + (BSW+1)'(chunk_bytes) ==
                      (BSW+1)'(blk_size_reg[BSW-1:0])));

    // R4: counted block decrements the counter by one
    assert_cnt_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_done && cnt_en) |=> (blk_cnt == $past(blk_cnt) - CW'(1)));

    // R4: counter holds when no block completes and no chain opens
    assert_cnt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk_done && !chain_start) |=> $stable(blk_cnt));

    // R9: chain start while idle clears the mismatch status
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_start && desc_ready) |=> !mismatch && (err_state == 2'b00));

    // R8: mismatch and error code agree
    assert_err_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |-> (err_state == 2'b11));

    // R10: card strobes follow direction
    assert_rd_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        card_rd_req |-> dir_read && chunk_valid && (chunk_offset == '0));
    assert_wr_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
        card_wr_push |-> !dir_read && blk_done);

    // R11: done only when idle again
    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> desc_ready && !chunk_valid);
endmodule

bind blk_seg_split blk_seg_split_chk #(.BSW(BSW), .CW(CW)) u_prop (
    .clk          (clk),
    .rst_n        (rst_n),
    .chain_start  (chain_start),
    .blk_size_reg (blk_size_reg),
    .dir_read     (dir_read),
    .cnt_en       (cnt_en),
    .desc_ready   (desc_ready),
    .chunk_valid  (chunk_valid),
    .chunk_offset (chunk_offset),
    .chunk_bytes  (chunk_bytes),
    .blk_done     (blk_done),
    .card_rd_req  (card_rd_req),
    .card_wr_push (card_wr_push),
    .blk_cnt      (blk_cnt),
    .done         (done),
    .mismatch     (mismatch),
    .err_state    (err_state)
);

// File: tb/sim_blk_seg_split.sv
// Directed bench for blk_seg_split with its own reference model.
module sim_blk_seg_split;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chain_start = 1'b0;
    logic [15:0] blk_size_reg = 16'd512;
    logic        dir_read = 1'b0;
    logic        cnt_en = 1'b0;
    logic [15:0] blk_cnt_init = 16'd0;
    logic        err_irq_en = 1'b0;
    logic        desc_valid = 1'b0;
    logic [15:0] desc_len = 16'd0;
    logic        desc_end = 1'b0;
    logic        desc_ready, chunk_valid, blk_done, card_rd_req, card_wr_push;
    logic        done, mismatch, err_irq;
    logic [11:0] chunk_offset, chunk_bytes;
    logic [15:0] blk_cnt;
    logic [1:0]  err_state;

    int total = 0;
    int bad = 0;
    int g_bs, m_fill, m_cnt;
    bit g_read, g_cen, g_irq;

    always #5 clk = ~clk;

    blk_seg_split u0 (
        .clk(clk), .rst_n(rst_n), .chain_start(chain_start),
        .blk_size_reg(blk_size_reg), .dir_read(dir_read), .cnt_en(cnt_en),
        .blk_cnt_init(blk_cnt_init), .err_irq_en(err_irq_en),
        .desc_valid(desc_valid), .desc_len(desc_len), .desc_end(desc_end),
        .desc_ready(desc_ready), .chunk_valid(chunk_valid),
        .chunk_offset(chunk_offset), .chunk_bytes(chunk_bytes),
        .blk_done(blk_done), .card_rd_req(card_rd_req),
        .card_wr_push(card_wr_push), .blk_cnt(blk_cnt), .done(done),
        .mismatch(mismatch), .err_state(err_state), .err_irq(err_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic start_chain(input logic [15:0] bsr, input bit rd, input bit cen,
                               input int cnt, input bit irq);
        @(negedge clk);
        blk_size_reg = bsr; dir_read = rd; cnt_en = cen;
        blk_cnt_init = 16'(cnt); err_irq_en = irq; chain_start = 1'b1;
        @(negedge clk);
        chain_start = 1'b0;
        g_bs = int'(bsr[11:0]); g_read = rd; g_cen = cen; g_irq = irq;
        m_fill = 0; m_cnt = cnt;
        chk(blk_cnt == 16'(cnt), "R9 count load", int'(blk_cnt), cnt);
        chk(mismatch == 1'b0 && err_irq == 1'b0 && err_state == 2'b00,
            "R9 status clear", int'(mismatch), 0);
    endtask

    // drives one descriptor, checks every chunk and the end-of-descriptor state
    task automatic run_desc(input int len, input bit endf);
        int  rem;
        bit  stop;
        bit  fin;
        bit  mm;
        desc_valid = 1'b1; desc_len = 16'(len); desc_end = endf;
        @(posedge clk);
        @(negedge clk);
        desc_valid = 1'b0;
        rem = (len == 0) ? 65536 : len;
        stop = 1'b0;
        while (!stop) begin
            int room, take;
            bit full;
            room = g_bs - m_fill;
            take = (rem < room) ? rem : room;
            full = (take == room);
            chk(chunk_valid == 1'b1, "R2 chunk valid", int'(chunk_valid), 1);
            chk(int'(chunk_offset) == m_fill, "R3 chunk offset", int'(chunk_offset), m_fill);
            chk(int'(chunk_bytes) == take, "R2 chunk bytes", int'(chunk_bytes), take);
            chk(blk_done == full, "R3 block strobe", int'(blk_done), int'(full));
            chk(card_rd_req == (g_read && m_fill == 0), "R10 read request",
                int'(card_rd_req), int'(g_read && m_fill == 0));
            chk(card_wr_push == (!g_read && full), "R10 write push",
                int'(card_wr_push), int'(!g_read && full));
            rem -= take;
            if (full) begin
                m_fill = 0;
                if (g_cen) m_cnt--;
            end else begin
                m_fill += take;
            end
            stop = (rem == 0) || (g_cen && full && m_cnt == 0);
            @(negedge clk);
        end
        fin = endf || (g_cen && m_cnt == 0);
        mm  = (rem != 0) || (endf && g_cen && m_cnt != 0) || (g_cen && m_cnt == 0 && !endf);
        chk(chunk_valid == 1'b0 && desc_ready == 1'b1, "R11 idle after descriptor",
            int'(chunk_valid), 0);
        chk(int'(blk_cnt) == m_cnt, "R4 block count", int'(blk_cnt), m_cnt);
        chk(done == fin, "R11 done pulse", int'(done), int'(fin));
        if (fin) begin
            chk(mismatch == mm, "R7 mismatch", int'(mismatch), int'(mm));
            chk(err_state == (mm ? 2'b11 : 2'b00), "R8 error code", int'(err_state),
                mm ? 3 : 0);
            chk(err_irq == (mm && g_irq), "R8 error interrupt", int'(err_irq),
                int'(mm && g_irq));
            @(negedge clk);
            chk(done == 1'b0, "R11 done one cycle", int'(done), 0);
        end
    endtask

    task automatic t_reset;
        chk(desc_ready == 1'b1 && chunk_valid == 1'b0, "R11 reset idle", int'(desc_ready), 1);
        chk(done == 1'b0 && mismatch == 1'b0 && err_irq == 1'b0, "R8 reset status",
            int'(mismatch), 0);
    endtask

    // R1 R3 R4: write across two descriptors with carried partial block, upper size bits set
    task automatic t_carry_write;
        start_chain(16'hF200, 1'b0, 1'b1, 2, 1'b1);
        run_desc(300, 1'b0);
        run_desc(724, 1'b1);
    endtask

    // R2 R10: read, no counting, short last chunk
    task automatic t_read_nocount;
        start_chain(16'd100, 1'b1, 1'b0, 7, 1'b1);
        run_desc(250, 1'b1);
        chk(blk_cnt == 16'd7, "R4 count unchanged without enable", int'(blk_cnt), 7);
    endtask

    // R5 R7: count exhausted with bytes left
    task automatic t_leftover;
        start_chain(16'd64, 1'b0, 1'b1, 1, 1'b1);
        run_desc(200, 1'b1);
    endtask

    // R7 R8: end marker with count nonzero, interrupt disabled
    task automatic t_end_early;
        start_chain(16'd64, 1'b1, 1'b1, 3, 1'b0);
        run_desc(64, 1'b1);
    endtask

    // R7 R9: count reaches zero without end marker, then new chain clears
    task automatic t_no_end;
        start_chain(16'd32, 1'b0, 1'b1, 1, 1'b1);
        run_desc(32, 1'b0);
        start_chain(16'd32, 1'b0, 1'b1, 1, 1'b1);
    endtask

    // R6: zero length means 65536 bytes
    task automatic t_zero_len;
        start_chain(16'd4095, 1'b1, 1'b0, 0, 1'b1);
        run_desc(0, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_carry_write();
        t_read_nocount();
        t_leftover();
        t_end_early();
        t_no_end();
        t_zero_len();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule